// File: doc/BRIEF.md
# I2C Line Conditioner with Glitch Rejection and SDA Hold

This block cleans up the two wires of an I2C port before they reach protocol logic. Each raw line is first brought into the local clock domain through a short flip-flop synchroniser. It then passes through a small state machine that removes pulses. A new level is accepted only after it has persisted for longer than a programmable number of clock cycles. The same rejection width is used for both wires.

The cleaned data line is then delayed by a programmable internal hold. The delay is counted in steps of five clock cycles, so data changes reach the protocol logic later than clock changes. The block also produces one-cycle strobes for the rising and falling edges of the cleaned clock line. At the nominal 100 MHz clock, one depth step is 10 ns and one hold step is 50 ns.

Settings come from a configuration byte, which carries the depth in its low four bits and the hold in the next three. New settings are copied into the working registers only while both cleaned lines rest high. Each line's filter is a four-state machine. FLT_LOW goes to FLT_RISE when a high is seen, or straight to FLT_HIGH when the depth is zero. FLT_RISE goes to FLT_HIGH after enough consecutive highs, and back to FLT_LOW on any low. FLT_HIGH and FLT_FALL mirror these transitions for the falling direction.

Top module: `bus_line_conditioner`

## Requirements
- R1: A level change on a raw input first sampled at clock edge 1 appears on the cleaned output at edge depth+3. This is two synchroniser stages plus depth+1 agreeing filter samples.
- R2: On the clock line, a pulse of w cycles is removed completely when w <= depth. When w > depth, it appears at the output with exactly w cycles of width.
- R3: The data line uses the same depth and the same pulse rule as the clock line.
- R4: With depth 0, each input reaches its cleaned output three edges after first sampling, so the filter adds only its register.
- R5: The data output lags the cleaned data by 5*hold cycles; the hold field is cfg_in[6:4]. With hold 0 no delay is added, and the data latency becomes 3+depth+5*hold.
- R6: After reset, scl_out and sda_out are 1 and both strobes are 0. The working depth is 7 and the working hold is 1, so the clock latency is 10 and the data latency is 15.
- R7: Bit 7 of cfg_in has no effect on behaviour. The depth field is cfg_in[3:0].
- R8: A new depth or hold is taken into the working registers only in cycles where both cleaned lines are high. While the clock line is low, the earlier settings remain in force.
- R9: scl_rise and scl_fall are each one cycle wide. They assert in the cycle in which scl_out takes its new level and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 8 | Configuration: [3:0] depth, [6:4] hold, [7] ignored |
| scl_in | input | 1 | Raw clock line |
| sda_in | input | 1 | Raw data line |
| scl_out | output | 1 | Cleaned clock line |
| sda_out | output | 1 | Cleaned and hold-delayed data line |
| scl_rise | output | 1 | One-cycle strobe on a cleaned clock rising edge |
| scl_fall | output | 1 | One-cycle strobe on a cleaned clock falling edge |

## Verification
The bench builds the block with its default parameters: a 4-bit depth, a 3-bit hold, a hold step of five cycles and two synchroniser stages. With these widths, every one of the 16 depths can be swept against every pulse width up to two beyond the rejection limit. Every one of the 8 hold values can also be timed edge by edge. Expected widths and latencies follow from depth+3 and 5*hold. The bench additionally exercises reset defaults, the ignored top bit, and the rule that settings are frozen while the clock line is low.

// File: rtl/bus_line_cond_pkg.sv
package bus_line_cond_pkg;

    typedef enum logic [1:0] {
        FLT_LOW  = 2'd0,
        FLT_RISE = 2'd1,
        FLT_HIGH = 2'd2,
        FLT_FALL = 2'd3
    } flt_state_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/glitch_fsm.sv
module glitch_fsm
    import bus_line_cond_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_in,
    input  logic [CNT_W-1:0] depth,
    output logic             level
);

    flt_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RST_LEVEL ? FLT_HIGH : FLT_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // transitions: a new level must win depth+1 consecutive samples
    always_comb begin
        st_nx  = st;
        cnt_nx = '0;
        unique case (st)
            FLT_LOW: begin
                if (s_in) begin
                    if (depth == '0) begin
                        st_nx = FLT_HIGH;
                    end else begin
                        st_nx  = FLT_RISE;
                        cnt_nx = CNT_W'(1);
                    end
                end
            end
            FLT_RISE: begin
                if (!s_in) begin
                    st_nx = FLT_LOW;
                end else if (cnt >= depth) begin
                    st_nx = FLT_HIGH;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            FLT_HIGH: begin
                if (!s_in) begin
                    if (depth == '0) begin
                        st_nx = FLT_LOW;
                    end else begin
                        st_nx  = FLT_FALL;
                        cnt_nx = CNT_W'(1);
                    end
                end
            end
            FLT_FALL: begin
                if (s_in) begin
                    st_nx = FLT_HIGH;
                end else if (cnt >= depth) begin
                    st_nx = FLT_LOW;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                st_nx = FLT_HIGH;
            end
        endcase
    end

    // outputs
    always_comb begin
        level = (st == FLT_HIGH) || (st == FLT_FALL);
    end

endmodule

// File: rtl/hold_line.sv
module hold_line #(
    parameter int HOLD_W = 3,
    parameter int UNIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_in,
    input  logic [HOLD_W-1:0] hold,
    output logic              d_out
);

    localparam int MAX_DLY = ((1 << HOLD_W) - 1) * UNIT;
    localparam int TAP_W   = $clog2(MAX_DLY);

    logic [MAX_DLY-1:0] line_q;
    logic [TAP_W-1:0]   tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '1;
        end else begin
            line_q <= {line_q[MAX_DLY-2:0], d_in};
        end
    end

    always_comb begin
        tap = TAP_W'(int'(hold) * UNIT - 1);
        if (hold == '0) begin
            d_out = d_in;
        end else begin
            d_out = line_q[tap];
        end
    end

endmodule

// File: rtl/bus_line_conditioner.sv
module bus_line_conditioner #(
    parameter int DEPTH_W     = 4,
    parameter int HOLD_W      = 3,
    parameter int HOLD_UNIT   = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH_RST   = 7,
    parameter int HOLD_RST    = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH_W+HOLD_W:0]   cfg_in,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      scl_out,
    output logic                      sda_out,
    output logic                      scl_rise,
    output logic                      scl_fall
);

    localparam int CFG_W = DEPTH_W + HOLD_W + 1;

    logic [1:0]         line_raw;
    logic [1:0]         line_sync;
    logic [1:0]         line_filt;
    logic [DEPTH_W-1:0] act_depth;
    logic [HOLD_W-1:0]  act_hold;
    logic               bus_idle;
    logic               scl_filt_q;
    logic               rsv_unused;

    assign line_raw   = {sda_in, scl_in};
    assign rsv_unused = cfg_in[CFG_W-1];

    // index 0 is the clock line, index 1 the data line
    for (genvar g = 0; g < 2; g++) begin : g_line
        line_sync #(
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (line_raw[g]),
            .q_out (line_sync[g])
        );

        glitch_fsm #(
            .CNT_W     (DEPTH_W),
            .RST_LEVEL (1'b1)
        ) i_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .s_in  (line_sync[g]),
            .depth (act_depth),
            .level (line_filt[g])
        );
    end

    assign bus_idle = line_filt[0] & line_filt[1];

    // working settings follow cfg_in only while the bus rests high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_depth <= DEPTH_W'(DEPTH_RST);
            act_hold  <= HOLD_W'(HOLD_RST);
        end else if (bus_idle) begin
            act_depth <= cfg_in[DEPTH_W-1:0];
            act_hold  <= cfg_in[DEPTH_W+HOLD_W-1:DEPTH_W];
        end
    end

    hold_line #(
        .HOLD_W (HOLD_W),
        .UNIT   (HOLD_UNIT)
    ) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_filt[1]),
        .hold  (act_hold),
        .d_out (sda_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_filt_q <= 1'b1;
        end else begin
            scl_filt_q <= line_filt[0];
        end
    end

    assign scl_out  = line_filt[0];
    assign scl_rise = line_filt[0] & ~scl_filt_q;
    assign scl_fall = ~line_filt[0] & scl_filt_q;

endmodule

// File: rtl/bus_line_conditioner_chk.sv
module bus_line_conditioner_chk #(
    parameter int DEPTH_W = 4,
    parameter int HOLD_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_out,
    input logic               sda_out,
    input logic               scl_rise,
    input logic               scl_fall,
    input logic               scl_sync,
    input logic               sda_sync,
    input logic               sda_filt,
    input logic [DEPTH_W-1:0] act_depth,
    input logic [HOLD_W-1:0]  act_hold
);

    // a cleaned clock change always adopts the synchronised level
    p_scl_follows_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out != $past(scl_out)) |-> (scl_out == $past(scl_sync)));

    // the data filter obeys the same rule
    p_sda_follows_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_filt != $past(sda_filt)) |-> (sda_filt == $past(sda_sync)));

    // zero hold means no delay on the data output
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hold == '0) |-> (sda_out == sda_filt));

    // settings frozen unless the bus rested high in the previous cycle
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(scl_out) && $past(sda_filt)) |-> ($stable(act_depth) && $stable(act_hold)));

    p_rise_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);

    p_fall_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall);

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    p_rise_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_out && !$past(scl_out)));

endmodule

bind bus_line_conditioner bus_line_conditioner_chk #(
    .DEPTH_W (DEPTH_W),
    .HOLD_W  (HOLD_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_out   (scl_out),
    .sda_out   (sda_out),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .scl_sync  (line_sync[0]),
    .sda_sync  (line_sync[1]),
    .sda_filt  (line_filt[1]),
    .act_depth (act_depth),
    .act_hold  (act_hold)
);

// File: tb/test_bus_line_conditioner.sv
module test_bus_line_conditioner;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_in;
    logic       scl_in;
    logic       sda_in;
    logic       scl_out;
    logic       sda_out;
    logic       scl_rise;
    logic       scl_fall;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bus_line_conditioner i_bus_line_conditioner (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_in   (cfg_in),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_out  (scl_out),
        .sda_out  (sda_out),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int rsv, input int hold, input int depth);
        @(negedge clk);
        cfg_in = 8'((rsv << 7) | (hold << 4) | depth);
        repeat (45) @(negedge clk);
    endtask

    // drive one line to lvl, count edges until its output follows;
    // strobe_ok stays 1 when the clock strobes behave per R9
    task automatic lat(input bit on_sda, input logic lvl, output int n, output int strobe_ok);
        bit seen = 1'b0;
        logic o;
        logic stb;
        @(negedge clk);
        if (on_sda) sda_in = lvl; else scl_in = lvl;
        n = 0;
        strobe_ok = 1;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(posedge clk);
            #1;
            n++;
            o   = on_sda ? sda_out : scl_out;
            stb = lvl ? scl_rise : scl_fall;
            if (!on_sda) begin
                if (scl_rise && scl_fall) strobe_ok = 0;
                if ((o == lvl) != stb) strobe_ok = 0;
            end
            if (o == lvl) seen = 1'b1;
        end
        @(posedge clk);
        #1;
        if (!on_sda && (scl_rise || scl_fall)) strobe_ok = 0;
    endtask

    task automatic pulse(input bit on_sda, input int w, input int d, output int lows, output int falls);
        logic prev = 1'b1;
        logic o;
        @(negedge clk);
        if (on_sda) sda_in = 1'b0; else scl_in = 1'b0;
        lows  = 0;
        falls = 0;
        for (int i = 0; i < w + d + 12; i++) begin
            @(posedge clk);
            #1;
            o = on_sda ? sda_out : scl_out;
            if (!o) lows++;
            if (prev && !o) falls++;
            prev = o;
            @(negedge clk);
            if (i == w - 1) begin
                if (on_sda) sda_in = 1'b1; else scl_in = 1'b1;
            end
        end
    endtask

    initial begin
        int n;
        int ok;
        int lows;
        int falls;
        rst_n  = 1'b0;
        cfg_in = 8'h17;
        scl_in = 1'b1;
        sda_in = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R6 reset state
        check("R6 scl_out in reset", int'(scl_out), 1);
        check("R6 sda_out in reset", int'(sda_out), 1);
        check("R6 strobes in reset", int'(scl_rise) + int'(scl_fall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 default depth 7: clock latency 10, data latency 15
        lat(1'b0, 1'b0, n, ok);
        check("R6 R1 default scl fall latency", n, 10);
        check("R9 fall strobe", ok, 1);
        lat(1'b0, 1'b1, n, ok);
        check("R6 R1 default scl rise latency", n, 10);
        check("R9 rise strobe", ok, 1);
        lat(1'b1, 1'b0, n, ok);
        check("R6 R5 default sda latency", n, 15);
        lat(1'b1, 1'b1, n, ok);
        check("R6 R5 default sda rise latency", n, 15);

        // R1 R2 R3 R4 sweep all depths
        for (int d = 0; d < 16; d++) begin
            set_cfg(0, 0, d);
            lat(1'b0, 1'b0, n, ok);
            check(d == 0 ? "R4 scl latency depth0" : "R1 scl latency", n, d + 3);
            lat(1'b0, 1'b1, n, ok);
            check("R1 scl rise latency", n, d + 3);
            check("R9 strobe timing", ok, 1);
            repeat (5) @(negedge clk);
            for (int w = 1; w <= d + 2; w++) begin
                pulse(1'b0, w, d, lows, falls);
                check("R2 scl pulse width", lows, (w > d) ? w : 0);
                check("R2 scl pulse count", falls, (w > d) ? 1 : 0);
            end
            for (int w = (d > 0 ? d : 1); w <= d + 1; w++) begin
                pulse(1'b1, w, d, lows, falls);
                check("R3 sda pulse width", lows, (w > d) ? w : 0);
                repeat (5) @(negedge clk);
            end
            lat(1'b1, 1'b0, n, ok);
            check(d == 0 ? "R4 sda latency depth0" : "R3 sda latency", n, d + 3);
            lat(1'b1, 1'b1, n, ok);
            check("R3 sda rise latency", n, d + 3);
        end

        // R5 every hold value
        for (int h = 0; h < 8; h++) begin
            set_cfg(0, h, 0);
            lat(1'b1, 1'b0, n, ok);
            check("R5 sda hold latency", n, 3 + 5 * h);
            lat(1'b1, 1'b1, n, ok);
            check("R5 sda hold release", n, 3 + 5 * h);
            repeat (40) @(negedge clk);
        end
        set_cfg(0, 2, 4);
        lat(1'b1, 1'b0, n, ok);
        check("R5 combined depth and hold", n, 17);
        lat(1'b1, 1'b1, n, ok);
        repeat (40) @(negedge clk);

        // R7 top bit ignored
        set_cfg(1, 0, 2);
        lat(1'b0, 1'b0, n, ok);
        check("R7 latency with bit7 set", n, 5);
        lat(1'b0, 1'b1, n, ok);
        pulse(1'b0, 2, 2, lows, falls);
        check("R7 short pulse removed", lows, 0);
        pulse(1'b0, 3, 2, lows, falls);
        check("R7 long pulse kept", lows, 3);

        // R8 settings frozen while clock line low
        set_cfg(0, 0, 2);
        lat(1'b0, 1'b0, n, ok);
        check("R8 latency before change", n, 5);
        @(negedge clk);
        cfg_in = 8'h09;
        repeat (6) @(negedge clk);
        lat(1'b0, 1'b1, n, ok);
        check("R8 old depth while low", n, 5);
        repeat (5) @(negedge clk);
        lat(1'b0, 1'b0, n, ok);
        check("R8 new depth after idle", n, 12);
        lat(1'b0, 1'b1, n, ok);
        check("R8 new depth rise", n, 12);

        finish_run();
    end

endmodule